// File: doc/BRIEF.md
# PCI Bridge Reset Sequencer

This block generates and orders every reset of a two-port PCI-to-PCI bridge. It works in the primary clock domain. The primary bus reset arrives asynchronously and active-low. The block asserts its internal reset at once and releases it through a two-stage synchronizer. From that internal reset it derives several outputs: the secondary bus reset, the output-enable controls for both bus sides, the drive-low controls that park the secondary bus, a register-default reset and a buffer-flush request.

Software can also reset the secondary bus through two configuration bits. The first is a secondary-reset bit in the bridge control register. It holds the secondary bus in reset until software writes the bit back to 0, and configuration access stays available the whole time. The second is a chip-reset bit in the diagnostic register. It returns the registers to their defaults for one cycle and latches the secondary-reset bit, so the secondary bus stays in reset until software clears that bit. After a primary reset, configuration access is refused for a fixed hold-off of 16 clocks. During the release, the primary 64-bit request line is sampled and the result is held as the primary 64-bit enable flag.

Top module: `pci_bridge_rst_seq`

## Requirements
- R1: When `prst_n` goes low, with no clock edge needed, `sec_rst_n` goes 0, `pri_oe` goes 0, `cfg_ready` goes 0, `regs_dflt` goes 1 and `buf_flush` goes 1. They stay so while `prst_n` is low.
- R2: After `prst_n` rises, `pri_oe` and `sec_rst_n` go to 1 at the second rising clock edge, provided no software reset is pending. `regs_dflt` and `buf_flush` go to 0 at that same edge.
- R3: `cfg_ready` goes to 1 at the 18th rising edge after `prst_n` rises. That is two synchronizer edges plus a 16-clock hold-off. It then stays 1 until the next primary reset.
- R4: A write of 1 to the secondary-reset bit (`wr_bctl`=1, `bctl_srst`=1) drives `sec_rst_n` to 0 from the clock edge of the write. It stays 0 until a write of 0 to that bit. `cfg_ready` stays 1 throughout.
- R5: Each software-caused assertion of secondary reset raises `buf_flush` for exactly one cycle, starting at the edge of the write. No pulse is produced on release, or by a write while secondary reset is already asserted.
- R6: While `sec_rst_n` is 0, the outputs are `sec_ctl_oe`=0, `sec_bus_low`=1 and `sec_req64_low`=1. While `sec_rst_n` is 1, the outputs are `sec_ctl_oe`=1, `sec_bus_low`=0 and `sec_req64_low`=0.
- R7: A write of 1 to the chip-reset bit (`wr_diag`=1, `diag_chip`=1) raises `regs_dflt` for one cycle and sets the secondary-reset bit. `sec_rst_n` then stays 0 until a write of 0 to the secondary-reset bit. The chip-reset bit clears itself. A write of 0 to it has no effect.
- R8: When a write of 0 to the secondary-reset bit and a write of 1 to the chip-reset bit occur at the same edge, the secondary-reset bit ends up set.
- R9: `pri64_en` takes the inverse of the active-low input `req64_n` as sampled at the third rising edge after `prst_n` rises. It ignores later changes of `req64_n` and is cleared by primary reset.
- R10: A primary reset clears a pending secondary-reset bit. After the release, `sec_rst_n` returns to 1 at the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| prst_n | input | 1 | Primary bus reset, asynchronous, active low |
| wr_bctl | input | 1 | Configuration write strobe, bridge control register |
| bctl_srst | input | 1 | Value written to the secondary-reset bit |
| wr_diag | input | 1 | Configuration write strobe, diagnostic register |
| diag_chip | input | 1 | Value written to the chip-reset bit |
| req64_n | input | 1 | Primary 64-bit request line, active low |
| sec_rst_n | output | 1 | Secondary bus reset, active low |
| cfg_ready | output | 1 | Configuration access may be accepted |
| buf_flush | output | 1 | Discard posted-write and delayed-transaction buffers |
| pri_oe | output | 1 | Output enable for primary interface signals |
| sec_ctl_oe | output | 1 | Output enable for secondary control signals and grants |
| sec_bus_low | output | 1 | Drive secondary address/data, byte-enables and parity low |
| sec_req64_low | output | 1 | Drive secondary 64-bit request low |
| regs_dflt | output | 1 | Return registers to their default values |
| pri64_en | output | 1 | 64-bit extension enabled on the primary side |

## Verification
The effects of primary reset assertion are combinational, so the bench checks them one time step after `prst_n` falls, with no clock edge in between. Release effects are due at the second rising edge after `prst_n` rises, the 64-bit sample at the third and `cfg_ready` at the eighteenth. The bench counts falling edges from a release made at a falling edge, so it samples one edge before and one edge after each due point. Software writes are driven at a falling edge and take effect at the next rising edge. The bench checks the reset level, `buf_flush` and `regs_dflt` at the following falling edge, and checks again one cycle later to confirm that each pulse lasted a single cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // State of the software secondary-reset logic
    typedef struct packed {
        logic sec_bit;   // latched secondary-reset control bit
        logic req;       // combined secondary-reset request, previous cycle
        logic flush;     // one-cycle buffer flush pulse
        logic dflt;      // one-cycle register-default pulse
    } sec_state_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_n
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rel_n = chain_q[STAGES-1];

    initial begin
        stages_min_chk: assert (STAGES >= 2);
    end
endmodule

// File: rtl/cfg_holdoff.sv
module cfg_holdoff #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rel_n,
    input  logic req64_n,
    output logic ready,
    output logic p64_en
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          p64;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt != CW'(HOLD))
            s_d.cnt = s_q.cnt + CW'(1);
        if (s_q.cnt == '0)
            s_d.p64 = ~req64_n;
    end

    always_ff @(posedge clk or negedge rel_n) begin
        if (!rel_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready  = (s_q.cnt == CW'(HOLD));
    assign p64_en = s_q.p64;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rel_n)
        s_q.cnt <= CW'(HOLD));
    // R3
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rel_n)
        ready |=> ready);
    // R9
    p64_hold_chk: assert property (@(posedge clk) disable iff (!rel_n)
        (s_q.cnt != '0) |=> $stable(p64_en));
endmodule

// File: rtl/sec_rst_ctrl.sv
module sec_rst_ctrl
    import rst_seq_pkg::*;
(
    input  logic clk,
    input  logic rel_n,
    input  logic wr_bctl,
    input  logic bctl_srst,
    input  logic wr_diag,
    input  logic diag_chip,
    output logic sec_rst_n,
    output logic flush,
    output logic dflt,
    output logic ctl_oe,
    output logic bus_low,
    output logic req64_low
);
    sec_state_t s_d, s_q;
    logic       chip_set;
    logic       prim_act;

    always_comb begin
        chip_set = wr_diag & diag_chip;
        s_d      = s_q;
        if (wr_bctl)  s_d.sec_bit = bctl_srst;
        if (chip_set) s_d.sec_bit = 1'b1;
        s_d.req   = s_d.sec_bit;
        s_d.flush = s_d.req & ~s_q.req;
        s_d.dflt  = chip_set;
    end

    always_ff @(posedge clk or negedge rel_n) begin
        if (!rel_n) s_q <= '{sec_bit: 1'b0, req: 1'b1, flush: 1'b0, dflt: 1'b0};
        else        s_q <= s_d;
    end

    assign prim_act  = ~rel_n;
    assign sec_rst_n = ~(prim_act | s_q.sec_bit);
    assign flush     = s_q.flush | prim_act;
    assign dflt      = s_q.dflt  | prim_act;
    assign ctl_oe    = sec_rst_n;
    assign bus_low   = ~sec_rst_n;
    assign req64_low = ~sec_rst_n;

    // R5
    flush_single_chk: assert property (@(posedge clk) disable iff (!rel_n)
        s_q.flush |=> !s_q.flush);
    // R4
    bit_clear_src_chk: assert property (@(posedge clk) disable iff (!rel_n)
        $fell(s_q.sec_bit) |-> $past(wr_bctl && !bctl_srst));
    // R8
    bit_set_src_chk: assert property (@(posedge clk) disable iff (!rel_n)
        $rose(s_q.sec_bit) |-> $past((wr_bctl && bctl_srst) || (wr_diag && diag_chip)));
    // R7
    dflt_in_reset_chk: assert property (@(posedge clk) disable iff (!rel_n)
        s_q.dflt |-> !sec_rst_n);
endmodule

// File: rtl/pci_bridge_rst_seq.sv
module pci_bridge_rst_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int CFG_HOLD    = 16
) (
    input  logic clk,
    input  logic prst_n,
    input  logic wr_bctl,
    input  logic bctl_srst,
    input  logic wr_diag,
    input  logic diag_chip,
    input  logic req64_n,
    output logic sec_rst_n,
    output logic cfg_ready,
    output logic buf_flush,
    output logic pri_oe,
    output logic sec_ctl_oe,
    output logic sec_bus_low,
    output logic sec_req64_low,
    output logic regs_dflt,
    output logic pri64_en
);
    logic rel_n;

    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (prst_n),
        .rel_n  (rel_n)
    );

    cfg_holdoff #(.HOLD(CFG_HOLD)) u_hold (
        .clk     (clk),
        .rel_n   (rel_n),
        .req64_n (req64_n),
        .ready   (cfg_ready),
        .p64_en  (pri64_en)
    );

    sec_rst_ctrl u_sec (
        .clk       (clk),
        .rel_n     (rel_n),
        .wr_bctl   (wr_bctl),
        .bctl_srst (bctl_srst),
        .wr_diag   (wr_diag),
        .diag_chip (diag_chip),
        .sec_rst_n (sec_rst_n),
        .flush     (buf_flush),
        .dflt      (regs_dflt),
        .ctl_oe    (sec_ctl_oe),
        .bus_low   (sec_bus_low),
        .req64_low (sec_req64_low)
    );

    assign pri_oe = rel_n;

    // R4
    cfg_live_chk: assert property (@(posedge clk) disable iff (!rel_n)
        cfg_ready |=> cfg_ready);
    // R6
    sec_park_chk: assert property (@(posedge clk) disable iff (!rel_n)
        !sec_rst_n |-> (!sec_ctl_oe && sec_bus_low && sec_req64_low));
endmodule

// File: tb/sim_pci_bridge_rst_seq.sv
`timescale 1ns/1ps
module sim_pci_bridge_rst_seq;
    logic clk = 1'b0;
    logic prst_n = 1'b0;
    logic wr_bctl = 1'b0, bctl_srst = 1'b0, wr_diag = 1'b0, diag_chip = 1'b0;
    logic req64_n = 1'b1;
    logic sec_rst_n, cfg_ready, buf_flush, pri_oe, sec_ctl_oe;
    logic sec_bus_low, sec_req64_low, regs_dflt, pri64_en;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    pci_bridge_rst_seq u0 (
        .clk(clk), .prst_n(prst_n), .wr_bctl(wr_bctl), .bctl_srst(bctl_srst),
        .wr_diag(wr_diag), .diag_chip(diag_chip), .req64_n(req64_n),
        .sec_rst_n(sec_rst_n), .cfg_ready(cfg_ready), .buf_flush(buf_flush),
        .pri_oe(pri_oe), .sec_ctl_oe(sec_ctl_oe), .sec_bus_low(sec_bus_low),
        .sec_req64_low(sec_req64_low), .regs_dflt(regs_dflt), .pri64_en(pri64_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_park(input string req, input logic in_rst);
        chk({req, " sec_rst_n"},  sec_rst_n,     ~in_rst);
        chk({req, " ctl_oe"},     sec_ctl_oe,    ~in_rst);
        chk({req, " bus_low"},    sec_bus_low,   in_rst);
        chk({req, " req64_low"},  sec_req64_low, in_rst);
    endtask

    task automatic cfg_write(input logic b_en, input logic b_v, input logic d_en, input logic d_v);
        @(negedge clk);
        wr_bctl = b_en; bctl_srst = b_v; wr_diag = d_en; diag_chip = d_v;
        @(negedge clk);
        wr_bctl = 0; bctl_srst = 0; wr_diag = 0; diag_chip = 0;
    endtask

    // Release at a negedge; stop after the 18th rising edge.
    task automatic t_release(input logic r64);
        @(negedge clk);
        req64_n = r64;
        prst_n  = 1'b1;
        @(negedge clk);                               // after edge 1
        chk("R2 pri_oe edge1", pri_oe, 1'b0);
        chk("R2 sec_rst_n edge1", sec_rst_n, 1'b0);
        @(negedge clk);                               // after edge 2
        chk("R2 pri_oe edge2", pri_oe, 1'b1);
        chk("R2 regs_dflt edge2", regs_dflt, 1'b0);
        chk("R2 buf_flush edge2", buf_flush, 1'b0);
        chk_park("R6 released", 1'b0);
        chk("R9 before sample", pri64_en, 1'b0);
        @(negedge clk);                               // after edge 3
        chk("R9 sampled", pri64_en, ~r64);
        req64_n = ~r64;
        for (int i = 4; i <= 17; i++) @(negedge clk);
        chk("R3 not ready edge17", cfg_ready, 1'b0);
        @(negedge clk);
        chk("R3 ready edge18", cfg_ready, 1'b1);
        chk("R9 held", pri64_en, ~r64);
    endtask

    task automatic t_prim_assert;
        #1 prst_n = 1'b0;
        #0.5;
        chk("R1 sec_rst_n", sec_rst_n, 1'b0);
        chk("R1 pri_oe", pri_oe, 1'b0);
        chk("R1 cfg_ready", cfg_ready, 1'b0);
        chk("R1 regs_dflt", regs_dflt, 1'b1);
        chk("R1 buf_flush", buf_flush, 1'b1);
        chk("R9 cleared", pri64_en, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 held", sec_rst_n, 1'b0);
    endtask

    task automatic t_sec_bit;
        cfg_write(1, 1, 0, 0);
        chk_park("R6 sw reset", 1'b1);
        chk("R5 flush", buf_flush, 1'b1);
        chk("R4 cfg live", cfg_ready, 1'b1);
        chk("R4 no dflt", regs_dflt, 1'b0);
        @(negedge clk);
        chk("R5 flush one cycle", buf_flush, 1'b0);
        chk("R4 held", sec_rst_n, 1'b0);
        cfg_write(1, 1, 0, 0);
        chk("R5 no repeat flush", buf_flush, 1'b0);
        cfg_write(0, 0, 1, 0);
        chk("R7 zero write ignored", sec_rst_n, 1'b0);
        chk("R7 zero write no dflt", regs_dflt, 1'b0);
        cfg_write(1, 0, 0, 0);
        chk_park("R4 cleared", 1'b0);
        chk("R5 no flush on release", buf_flush, 1'b0);
        chk("R4 cfg after", cfg_ready, 1'b1);
    endtask

    task automatic t_chip;
        cfg_write(0, 0, 1, 1);
        chk("R7 dflt", regs_dflt, 1'b1);
        chk("R7 sec reset", sec_rst_n, 1'b0);
        chk("R5 chip flush", buf_flush, 1'b1);
        @(negedge clk);
        chk("R7 dflt one cycle", regs_dflt, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 held", sec_rst_n, 1'b0);
        cfg_write(1, 0, 0, 0);
        chk("R7 cleared by bctl", sec_rst_n, 1'b1);
    endtask

    task automatic t_same_edge;
        cfg_write(1, 0, 1, 1);
        chk("R8 set wins", sec_rst_n, 1'b0);
        @(negedge clk);
        chk("R8 still set", sec_rst_n, 1'b0);
        cfg_write(1, 0, 0, 0);
        chk("R8 cleared", sec_rst_n, 1'b1);
    endtask

    task automatic t_prim_clears_bit;
        cfg_write(1, 1, 0, 0);
        chk("R10 set", sec_rst_n, 1'b0);
        t_prim_assert();
        @(negedge clk);
        prst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 bit cleared", sec_rst_n, 1'b1);
    endtask

    initial begin
        #1.5;
        chk("R1 reset pri_oe", pri_oe, 1'b0);
        chk("R1 reset sec_rst_n", sec_rst_n, 1'b0);
        chk("R1 reset regs_dflt", regs_dflt, 1'b1);
        chk_park("R6 in reset", 1'b1);
        repeat (3) @(negedge clk);
        t_release(1'b0);
        t_sec_bit();
        t_chip();
        t_same_edge();
        @(negedge clk);
        t_prim_assert();
        t_release(1'b1);
        t_prim_clears_bit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule